// File: doc/BRIEF.md
# DDR Write Burst Sequencer

This block sits on the controller side of a double-data-rate memory interface. It carries out one write burst of four data elements. A request carries a column address, an auto-precharge flag, four data words and four per-byte mask vectors. The request is taken through a ready/valid handshake. The block then issues the WRITE command with the precharge choice placed on address bit 10. It drives the data strobe low as a preamble, puts one data word and its mask on each strobe edge, and holds the strobe low for a postamble half cycle. After that it releases the data, mask and strobe buses.

The block runs on a clock at twice the memory clock rate, so one tick is half a memory cycle. The first rising strobe edge sits at the nominal placement, one full memory cycle (two ticks) after the start of the command. A request that arrives while a burst is in flight is held off by the handshake and is never dropped.

Top module: `ddr_wr_burst_seq`

## Requirements
- R1: While reset is high and on the first tick after it, `busy`, `cmd_wr`, `dq_oe` and `dqs_oe` are low and `req_ready` is high. `dq`, `dm`, `dqs` and `addr` are all zero.
- R2: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the bus release. A request held valid during that time is accepted after the release and carries its own data.
- R3: Ticks are counted from the first tick after acceptance, which is tick 0. `cmd_wr` is high on ticks 0 and 1 only. During those ticks `addr[9:0]` is the column, `addr[10]` is the auto-precharge flag (1 = precharge after the burst, 0 = leave the row open) and the upper address bits are zero. `addr` is zero on all other ticks.
- R4: On ticks 0 and 1 (the preamble), `dqs_oe` is high and `dqs` is low.
- R5: On tick 2+k, for k from 0 to 3, `dq` carries `req_data[16k+15:16k]` and `dq_oe` is high. `dq_oe` is low on every other tick, and `dq` is then zero.
- R6: `dqs` is high on ticks 2 and 4 and low on ticks 3 and 5. Its first rising edge therefore falls one memory cycle after the start of the command, and each later beat starts on the next strobe edge.
- R7: On tick 2+k, `dm` carries `req_mask[2k+1:2k]`. Bit j set to 1 blocks byte lane j (`dq[8j+7:8j]`) for that beat; bit j set to 0 lets it be written. `dm` is zero while `dq_oe` is low.
- R8: On tick 6 (the postamble), `dqs_oe` is high, `dqs` is low and `dq_oe` is low.
- R9: `busy` is high on ticks 0 to 6. On tick 7, `busy`, `dqs_oe` and `dq_oe` are low and `req_ready` is high. This idle state holds while no request is presented.
- R10: Changes on the request inputs after acceptance have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, twice the memory clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_col | input | 10 | Column address |
| req_ap | input | 1 | Auto-precharge after the burst |
| req_data | input | 64 | Four data words, beat 0 in the low bits |
| req_mask | input | 8 | Four byte-mask vectors, beat 0 in the low bits |
| cmd_wr | output | 1 | WRITE command strobe (one memory cycle) |
| addr | output | 13 | Command address, bit 10 carries auto-precharge |
| dq | output | 16 | Write data |
| dm | output | 2 | Per-byte write mask |
| dq_oe | output | 1 | Enable for the data and mask drivers |
| dqs | output | 1 | Data strobe |
| dqs_oe | output | 1 | Enable for the strobe driver |
| busy | output | 1 | Burst in progress |

## Verification
Random bursts vary the column, the precharge flag, the data words and the mask vectors. Because every beat carries a distinct random word and mask, any swap of beat order or of byte lanes shows up, as does a strobe edge off by one tick. Directed cases add an all-ones mask, a maximum column and both precharge values. Back-to-back requests, held valid through a whole burst, separate a correct hold-off from a dropped or early-accepted request. Random noise on the request inputs during a burst with valid low checks that captured values stay isolated, and idle gaps check that the buses remain released.

// File: rtl/ddr_wr_burst_seq_pkg.sv
package ddr_wr_burst_seq_pkg;

    localparam int BEATS    = 4;
    localparam int BEAT_IW  = $clog2(BEATS);
    localparam int BYTE_W   = 8;
    localparam int AP_BIT   = 10;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CMD0 = 3'd1,
        PH_CMD1 = 3'd2,
        PH_B0   = 3'd3,
        PH_B1   = 3'd4,
        PH_B2   = 3'd5,
        PH_B3   = 3'd6,
        PH_POST = 3'd7
    } phase_t;

    function automatic phase_t next_phase(input phase_t p);
        case (p)
            PH_CMD0: return PH_CMD1;
            PH_CMD1: return PH_B0;
            PH_B0:   return PH_B1;
            PH_B1:   return PH_B2;
            PH_B2:   return PH_B3;
            PH_B3:   return PH_POST;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic logic is_beat(input phase_t p);
        return (p == PH_B0) || (p == PH_B1) || (p == PH_B2) || (p == PH_B3);
    endfunction

    function automatic logic [BEAT_IW-1:0] beat_index(input phase_t p);
        case (p)
            PH_B1:   return BEAT_IW'(1);
            PH_B2:   return BEAT_IW'(2);
            PH_B3:   return BEAT_IW'(3);
            default: return BEAT_IW'(0);
        endcase
    endfunction

    // Strobe level: high on even beats so that each beat begins on an edge.
    function automatic logic strobe_level(input phase_t p);
        return (p == PH_B0) || (p == PH_B2);
    endfunction

endpackage

// File: rtl/ddr_wr_burst_seq_phase.sv
module ddr_wr_burst_seq_phase
    import ddr_wr_burst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    output logic   accept,
    output phase_t phase
);
    assign accept = req_valid && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else if (phase == PH_IDLE) begin
            if (accept) phase <= PH_CMD0;
        end else begin
            phase <= next_phase(phase);
        end
    end
endmodule

// File: rtl/ddr_wr_burst_seq_capture.sv
module ddr_wr_burst_seq_capture
    import ddr_wr_burst_seq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      accept,
    input  logic [COL_W-1:0]          in_col,
    input  logic                      in_ap,
    input  logic [BEATS*DATA_W-1:0]   in_data,
    input  logic [BEATS*LANES-1:0]    in_mask,
    output logic [COL_W-1:0]          hold_col,
    output logic                      hold_ap,
    output logic [BEATS*DATA_W-1:0]   hold_data,
    output logic [BEATS*LANES-1:0]    hold_mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_col  <= '0;
            hold_ap   <= 1'b0;
            hold_data <= '0;
            hold_mask <= '0;
        end else if (accept) begin
            hold_col  <= in_col;
            hold_ap   <= in_ap;
            hold_data <= in_data;
            hold_mask <= in_mask;
        end
    end
endmodule

// File: rtl/ddr_wr_burst_seq_drive.sv
module ddr_wr_burst_seq_drive
    import ddr_wr_burst_seq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  phase_t                    phase,
    input  logic [COL_W-1:0]          hold_col,
    input  logic                      hold_ap,
    input  logic [BEATS*DATA_W-1:0]   hold_data,
    input  logic [BEATS*LANES-1:0]    hold_mask,
    output logic                      cmd_wr,
    output logic [ADDR_W-1:0]         addr,
    output logic [DATA_W-1:0]         dq,
    output logic [LANES-1:0]          dm,
    output logic                      dq_oe,
    output logic                      dqs,
    output logic                      dqs_oe,
    output logic                      busy
);
    logic               in_cmd;
    logic               in_beat;
    logic [BEAT_IW-1:0] bsel;

    assign in_cmd  = (phase == PH_CMD0) || (phase == PH_CMD1);
    assign in_beat = is_beat(phase);
    assign bsel    = beat_index(phase);

    always_comb begin
        addr = '0;
        if (in_cmd) begin
            addr[COL_W-1:0] = hold_col;
            addr[AP_BIT]    = hold_ap;
        end
    end

    assign cmd_wr = in_cmd;
    assign dq     = in_beat ? hold_data[bsel*DATA_W +: DATA_W] : '0;
    assign dm     = in_beat ? hold_mask[bsel*LANES +: LANES]   : '0;
    assign dq_oe  = in_beat;
    assign dqs    = strobe_level(phase);
    assign dqs_oe = (phase != PH_IDLE);
    assign busy   = (phase != PH_IDLE);
endmodule

// File: rtl/ddr_wr_burst_seq.sv
module ddr_wr_burst_seq
    import ddr_wr_burst_seq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [COL_W-1:0]         req_col,
    input  logic                     req_ap,
    input  logic [BEATS*DATA_W-1:0]  req_data,
    input  logic [BEATS*LANES-1:0]   req_mask,
    output logic                     cmd_wr,
    output logic [ADDR_W-1:0]        addr,
    output logic [DATA_W-1:0]        dq,
    output logic [LANES-1:0]         dm,
    output logic                     dq_oe,
    output logic                     dqs,
    output logic                     dqs_oe,
    output logic                     busy
);
    phase_t                  phase;
    logic                    accept;
    logic [COL_W-1:0]        hold_col;
    logic                    hold_ap;
    logic [BEATS*DATA_W-1:0] hold_data;
    logic [BEATS*LANES-1:0]  hold_mask;

    assign req_ready = (phase == PH_IDLE);

    ddr_wr_burst_seq_phase u_phase (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .accept(accept), .phase(phase)
    );

    ddr_wr_burst_seq_capture #(.COL_W(COL_W), .DATA_W(DATA_W), .LANES(LANES)) u_capture (
        .clk(clk), .rst(rst), .accept(accept),
        .in_col(req_col), .in_ap(req_ap), .in_data(req_data), .in_mask(req_mask),
        .hold_col(hold_col), .hold_ap(hold_ap), .hold_data(hold_data), .hold_mask(hold_mask)
    );

    ddr_wr_burst_seq_drive #(.COL_W(COL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_drive (
        .phase(phase), .hold_col(hold_col), .hold_ap(hold_ap),
        .hold_data(hold_data), .hold_mask(hold_mask),
        .cmd_wr(cmd_wr), .addr(addr), .dq(dq), .dm(dm), .dq_oe(dq_oe),
        .dqs(dqs), .dqs_oe(dqs_oe), .busy(busy)
    );
endmodule

// File: rtl/ddr_wr_burst_seq_chk.sv
module ddr_wr_burst_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cmd_wr,
    input logic [ADDR_W-1:0] addr,
    input logic [LANES-1:0]  dm,
    input logic              dq_oe,
    input logic              dqs,
    input logic              dqs_oe,
    input logic              busy
);
    AST_BUSY_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst) busy |-> !req_ready); // R2
    AST_ACCEPT_STARTS_CMD: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> (cmd_wr && busy)); // R3
    AST_CMD_FULL_CYCLE: assert property (@(posedge clk) disable iff (rst) $rose(cmd_wr) |=> cmd_wr); // R3
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst) (cmd_wr && $past(cmd_wr)) |-> $stable(addr)); // R3
    AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (rst) $rose(dqs_oe) |-> !dqs); // R4
    AST_DATA_IN_STROBE: assert property (@(posedge clk) disable iff (rst) dq_oe |-> dqs_oe); // R5
    AST_FIRST_RISE: assert property (@(posedge clk) disable iff (rst) $fell(cmd_wr) |-> (dqs && dq_oe)); // R6
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst) !dq_oe |-> (dm == '0)); // R7
    AST_POSTAMBLE: assert property (@(posedge clk) disable iff (rst) $fell(dq_oe) |-> (dqs_oe && !dqs)); // R8
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (!dqs_oe && !dq_oe)); // R9
endmodule

bind ddr_wr_burst_seq ddr_wr_burst_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cmd_wr(cmd_wr), .addr(addr), .dm(dm), .dq_oe(dq_oe), .dqs(dqs),
    .dqs_oe(dqs_oe), .busy(busy)
);

// File: tb/ddr_wr_burst_seq_bench.sv
module ddr_wr_burst_seq_bench;
    typedef struct packed {
        logic [9:0]  col;
        logic        ap;
        logic [63:0] data;
        logic [7:0]  mask;
    } req_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [9:0]  req_col = '0;
    logic        req_ap = 1'b0;
    logic [63:0] req_data = '0;
    logic [7:0]  req_mask = '0;
    logic        cmd_wr;
    logic [12:0] addr;
    logic [15:0] dq;
    logic [1:0]  dm;
    logic        dq_oe, dqs, dqs_oe, busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ddr_wr_burst_seq u_ddr_wr_burst_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_col(req_col), .req_ap(req_ap), .req_data(req_data), .req_mask(req_mask),
        .cmd_wr(cmd_wr), .addr(addr), .dq(dq), .dm(dm), .dq_oe(dq_oe),
        .dqs(dqs), .dqs_oe(dqs_oe), .busy(busy)
    );

    // Packed output view: {cmd, addr, dq, dm, dq_oe, dqs, dqs_oe, busy, ready}
    function automatic logic [36:0] actual();
        return {cmd_wr, addr, dq, dm, dq_oe, dqs, dqs_oe, busy, req_ready};
    endfunction

    function automatic logic [36:0] expect_tick(input int t, input req_t r);
        logic        e_cmd;
        logic [12:0] e_addr;
        logic [15:0] e_dq;
        logic [1:0]  e_dm;
        logic        e_beat;
        e_cmd  = (t < 2);
        e_addr = '0;
        if (e_cmd) e_addr = {2'b00, r.ap, r.col};
        e_beat = (t >= 2) && (t <= 5);
        e_dq   = '0;
        e_dm   = '0;
        if (e_beat) begin
            e_dq = r.data[16*(t-2) +: 16];
            e_dm = r.mask[2*(t-2) +: 2];
        end
        return {e_cmd, e_addr, e_dq, e_dm, e_beat, (t == 2) || (t == 4),
                (t <= 6), (t <= 6), (t == 7)};
    endfunction

    function automatic string tag_of(input int t);
        if (t < 2)  return "R3 R4";
        if (t <= 5) return "R5 R6 R7";
        if (t == 6) return "R8";
        return "R9";
    endfunction

    function automatic req_t rand_req();
        req_t r;
        r.col  = 10'($urandom);
        r.ap   = 1'($urandom);
        r.data = {$urandom, $urandom};
        r.mask = 8'($urandom);
        return r;
    endfunction

    task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
        end
    endtask

    task automatic drive(input req_t r);
        req_col  = r.col;
        req_ap   = r.ap;
        req_data = r.data;
        req_mask = r.mask;
    endtask

    // Called at a negedge; performs and checks one full burst.
    task automatic run_burst(input req_t r, input bit hold_next, input req_t nxt, input string extra);
        drive(r);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            if (t == 0) begin
                if (hold_next) begin
                    drive(nxt);               // R2: held request must wait
                    req_valid = 1'b1;
                end else begin
                    req_valid = 1'b0;
                    drive(rand_req());        // R10: noise after acceptance
                end
            end
            check({tag_of(t), " ", extra}, actual(), expect_tick(t, r));
        end
    endtask

    task automatic idle_gap(input int n);
        req_t z;
        z = '0;
        for (int i = 0; i < n; i++) begin
            drive(rand_req());
            @(negedge clk);
            check("R9 idle", actual(), expect_tick(7, z));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        req_t cur, nxt, z;
        bit   hold;
        z = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", actual(), expect_tick(7, z));
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", actual(), expect_tick(7, z));

        // Directed corners: precharge on, all lanes blocked, top column
        cur = '{col: 10'h3FF, ap: 1'b1, data: 64'h0123_4567_89AB_CDEF, mask: 8'hFF};
        run_burst(cur, 1'b0, z, "R7 all-masked");
        cur = '{col: 10'h000, ap: 1'b0, data: 64'hFFFF_0000_A5A5_5A5A, mask: 8'h00};
        run_burst(cur, 1'b0, z, "R3 ap-low");
        idle_gap(3);

        // Back-to-back hold-off with distinct data
        cur = '{col: 10'h155, ap: 1'b1, data: 64'h1111_2222_3333_4444, mask: 8'b10_01_00_11};
        nxt = '{col: 10'h2AA, ap: 1'b0, data: 64'h5555_6666_7777_8888, mask: 8'b01_10_11_00};
        run_burst(cur, 1'b1, nxt, "R2 first");
        run_burst(nxt, 1'b0, z, "R2 R10 held");

        // Random traffic
        cur = rand_req();
        for (int i = 0; i < 60; i++) begin
            nxt  = rand_req();
            hold = 1'($urandom);
            run_burst(cur, hold, nxt, "rand");
            if (hold) cur = nxt;
            else begin
                idle_gap(int'($urandom_range(0, 2)));
                cur = rand_req();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule